// File: doc/BRIEF.md
# Receive MSDU Descriptor Chain Assembler

This block sits on the receive path and consumes one 32-bit descriptor word per receive buffer. An MSDU may span several buffers: each buffer except the final one carries a continuation mark, and the block merges the chain into one summary record. It also follows the MSDU's position inside its MPDU. The byte length is latched from the opening buffer of the chain. Every other attribute is taken from the closing buffer, the one whose continuation mark is clear. These attributes are the position flags, drop, address-search validity, the checksum results, the distribution-system bits, routing and decapsulation format.

Words arrive on a valid/ready input. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. Records leave on a valid/ready output. A record stays frozen while `out_valid` is high and `out_ready` is low. `in_ready` equals `!out_valid || out_ready`, so the input stalls whenever a pending record is not being taken. Protocol problems produce a one-cycle pulse on `err_valid` with a code on `err_code`. Records marked for dropping are swallowed. The reset is synchronous and active high.

Top module: `rx_msdu_chain_asm`

## Requirements
- R1: During and after reset, `out_valid` and `err_valid` are 0 and `in_ready` is 1, and no MPDU is open.
- R2: A word with continuation (bit 2) clear closes an MSDU. Unless it is dropped, a record appears on the clock edge that accepts it. In that record, format comes from bits 30:29 (0 raw, 1 native WiFi, 2 Ethernet II, 3 802.3), from-DS from bit 24, to-DS from bit 25, SA valid from bit 18, DA valid from bit 19, L4 checksum failure from bit 22, IP checksum failure from bit 23, and first/last-in-MPDU from bits 0/1, all taken from the closing word.
- R3: Record length is bits 16:3 of the first word of the chain. Length fields of later buffers in the same chain are ignored.
- R4: A word with continuation (bit 2) and last-in-MPDU (bit 1) both set raises `err_valid` for one cycle with code 1. It also discards the open chain and emits no record for it.
- R5: `out_single` is 1 exactly when the closing word has both bit 0 and bit 1 set.
- R6: `out_mcast` equals bit 20 when bit 19 is set, and is 0 otherwise.
- R7: A closing word with drop (bit 17) set produces no record.
- R8: `out_pad` is 2 when bit 21 of the closing word is set, and 0 otherwise.
- R9: `out_chip` (bits 28:27) and `out_link` (bit 31) pass through only when intra-BSS (bit 26) is set, and are 0 otherwise.
- R10: A closing word with bit 0 set while an MPDU is open, or with bit 0 clear while none is open, raises `err_valid` with code 2. The record is still emitted unless dropped. After any closing word, an MPDU is open exactly when its bit 1 was clear.
- R11: While `out_valid` is high and `out_ready` low, the record holds unchanged and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Per-buffer descriptor word |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_len | output | 14 | MSDU byte length |
| out_fmt | output | 2 | Decapsulation format |
| out_chip | output | 2 | Destination chip (intra-BSS only) |
| out_link | output | 1 | Destination link (intra-BSS only) |
| out_intra | output | 1 | Intra-BSS routing needed |
| out_fr_ds | output | 1 | From-DS bit |
| out_to_ds | output | 1 | To-DS bit |
| out_sa_ok | output | 1 | Source address found |
| out_da_ok | output | 1 | Destination address found |
| out_mcast | output | 1 | Multicast/broadcast destination |
| out_pad | output | 2 | L3 header padding bytes (0 or 2) |
| out_l4_bad | output | 1 | TCP/UDP checksum failure |
| out_ip_bad | output | 1 | IP checksum failure |
| out_single | output | 1 | MPDU holds this single MSDU |
| out_mpdu_first | output | 1 | First MSDU of its MPDU |
| out_mpdu_last | output | 1 | Last MSDU of its MPDU |
| err_valid | output | 1 | One-cycle protocol error pulse |
| err_code | output | 2 | 1 continuation with last-in-MPDU, 2 MPDU sequencing |

## Verification
A closing word that breaks MPDU sequencing emits a record and an error pulse on the same edge. The bench provokes this by closing an MSDU without the first flag while no MPDU is open, and by opening a new MPDU on top of an open one. A reference model pushes both the expected record and the expected error code. Separate monitors pop each queue, so a design that drops either result, or swaps their order, leaves a mismatch or a non-empty queue. Back-pressure is also applied at random while words keep arriving. This makes record hand-off and new-word acceptance coincide on many edges.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 14;
  localparam int CHIP_W = 2;
  localparam int FMT_W  = 2;
  localparam int PAD_W  = 2;

  // bit positions inside the per-buffer word
  localparam int P_FIRST = 0;
  localparam int P_LAST  = 1;
  localparam int P_CONT  = 2;
  localparam int P_LEN   = 3;
  localparam int P_DROP  = 17;
  localparam int P_SA    = 18;
  localparam int P_DA    = 19;
  localparam int P_MCBC  = 20;
  localparam int P_PADM  = 21;
  localparam int P_L4BAD = 22;
  localparam int P_IPBAD = 23;
  localparam int P_FRDS  = 24;
  localparam int P_TODS  = 25;
  localparam int P_INTRA = 26;
  localparam int P_CHIP  = 27;
  localparam int P_FMT   = 29;
  localparam int P_LINK  = 31;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_CONT_LAST = 2'd1,
    ERR_SEQ       = 2'd2
  } rxc_err_e;

  typedef struct packed {
    logic              first;
    logic              last;
    logic              cont;
    logic [LEN_W-1:0]  len;
    logic              drop;
    logic              sa;
    logic              da;
    logic              mcbc;
    logic              padm;
    logic              l4bad;
    logic              ipbad;
    logic              frds;
    logic              tods;
    logic              intra;
    logic [CHIP_W-1:0] chip;
    logic [FMT_W-1:0]  fmt;
    logic              link;
  } rxc_word_t;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [FMT_W-1:0]  fmt;
    logic [CHIP_W-1:0] chip;
    logic              link;
    logic              intra;
    logic              frds;
    logic              tods;
    logic              sa;
    logic              da;
    logic              mcast;
    logic [PAD_W-1:0]  pad;
    logic              l4bad;
    logic              ipbad;
    logic              single;
    logic              first;
    logic              last;
  } rxc_rec_t;
endpackage

// File: rtl/rxc_word_decode.sv
module rxc_word_decode
  import rxc_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output rxc_word_t         fld
);
  always_comb begin
    fld.first = word[P_FIRST];
    fld.last  = word[P_LAST];
    fld.cont  = word[P_CONT];
    fld.len   = word[P_LEN +: LEN_W];
    fld.drop  = word[P_DROP];
    fld.sa    = word[P_SA];
    fld.da    = word[P_DA];
    fld.mcbc  = word[P_MCBC];
    fld.padm  = word[P_PADM];
    fld.l4bad = word[P_L4BAD];
    fld.ipbad = word[P_IPBAD];
    fld.frds  = word[P_FRDS];
    fld.tods  = word[P_TODS];
    fld.intra = word[P_INTRA];
    fld.chip  = word[P_CHIP +: CHIP_W];
    fld.fmt   = word[P_FMT +: FMT_W];
    fld.link  = word[P_LINK];
  end
endmodule

// File: rtl/rxc_chain_track.sv
module rxc_chain_track
  import rxc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      acc,
  input  rxc_word_t fld,
  output logic      rec_load,
  output rxc_rec_t  rec_d,
  output logic      err_valid,
  output rxc_err_e  err_code
);
  logic             in_msdu;
  logic             mpdu_open;
  logic [LEN_W-1:0] cap_len;
  logic             illegal;
  logic             closing;
  logic             seq_bad;

  always_comb begin
    illegal = fld.cont & fld.last;
    closing = ~fld.cont;
    seq_bad = closing & (fld.first == mpdu_open);
    rec_load = acc & closing & ~fld.drop;
  end

  // record assembled from the closing word plus the latched length
  always_comb begin
    rec_d.len    = in_msdu ? cap_len : fld.len;
    rec_d.fmt    = fld.fmt;
    rec_d.chip   = fld.intra ? fld.chip : '0;
    rec_d.link   = fld.intra & fld.link;
    rec_d.intra  = fld.intra;
    rec_d.frds   = fld.frds;
    rec_d.tods   = fld.tods;
    rec_d.sa     = fld.sa;
    rec_d.da     = fld.da;
    rec_d.mcast  = fld.da & fld.mcbc;
    rec_d.pad    = {fld.padm, 1'b0};
    rec_d.l4bad  = fld.l4bad;
    rec_d.ipbad  = fld.ipbad;
    rec_d.single = fld.first & fld.last;
    rec_d.first  = fld.first;
    rec_d.last   = fld.last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_msdu   <= 1'b0;
      mpdu_open <= 1'b0;
      cap_len   <= '0;
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
    end else begin
      err_valid <= 1'b0;
      err_code  <= ERR_NONE;
      if (acc) begin
        if (illegal) begin
          in_msdu   <= 1'b0;
          err_valid <= 1'b1;
          err_code  <= ERR_CONT_LAST;
        end else if (fld.cont) begin
          if (!in_msdu) cap_len <= fld.len;
          in_msdu <= 1'b1;
        end else begin
          in_msdu   <= 1'b0;
          mpdu_open <= ~fld.last;
          if (seq_bad) begin
            err_valid <= 1'b1;
            err_code  <= ERR_SEQ;
          end
        end
      end
    end
  end

  AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    acc && fld.cont && fld.last |=> err_valid && err_code == ERR_CONT_LAST); // R4
  AST_SEQ_REOPEN: assert property (@(posedge clk) disable iff (rst)
    acc && !fld.cont && fld.first && mpdu_open |=> err_valid && err_code == ERR_SEQ); // R10
  AST_SEQ_ORPHAN: assert property (@(posedge clk) disable iff (rst)
    acc && !fld.cont && !fld.first && !mpdu_open |=> err_valid && err_code == ERR_SEQ); // R10
  AST_OPEN_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
    acc && !fld.cont && !fld.last |=> mpdu_open); // R10
endmodule

// File: rtl/rxc_out_slot.sv
module rxc_out_slot
  import rxc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  rxc_rec_t rec_d,
  input  logic     out_ready,
  output logic     out_valid,
  output rxc_rec_t rec_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      rec_q     <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      rec_q     <= rec_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(rec_q)); // R11
endmodule

// File: rtl/rx_msdu_chain_asm.sv
module rx_msdu_chain_asm
  import rxc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  out_len,
  output logic [FMT_W-1:0]  out_fmt,
  output logic [CHIP_W-1:0] out_chip,
  output logic              out_link,
  output logic              out_intra,
  output logic              out_fr_ds,
  output logic              out_to_ds,
  output logic              out_sa_ok,
  output logic              out_da_ok,
  output logic              out_mcast,
  output logic [PAD_W-1:0]  out_pad,
  output logic              out_l4_bad,
  output logic              out_ip_bad,
  output logic              out_single,
  output logic              out_mpdu_first,
  output logic              out_mpdu_last,
  output logic              err_valid,
  output logic [1:0]        err_code
);
  rxc_word_t fld;
  rxc_rec_t  rec_d;
  rxc_rec_t  rec_q;
  rxc_err_e  err_e;
  logic      acc;
  logic      rec_load;

  assign in_ready = ~out_valid | out_ready;
  assign acc      = in_valid & in_ready;

  rxc_word_decode u_dec (
    .word (in_word),
    .fld  (fld)
  );

  rxc_chain_track u_trk (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .fld       (fld),
    .rec_load  (rec_load),
    .rec_d     (rec_d),
    .err_valid (err_valid),
    .err_code  (err_e)
  );

  rxc_out_slot u_slot (
    .clk       (clk),
    .rst       (rst),
    .load      (rec_load),
    .rec_d     (rec_d),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .rec_q     (rec_q)
  );

  assign err_code       = err_e;
  assign out_len        = rec_q.len;
  assign out_fmt        = rec_q.fmt;
  assign out_chip       = rec_q.chip;
  assign out_link       = rec_q.link;
  assign out_intra      = rec_q.intra;
  assign out_fr_ds      = rec_q.frds;
  assign out_to_ds      = rec_q.tods;
  assign out_sa_ok      = rec_q.sa;
  assign out_da_ok      = rec_q.da;
  assign out_mcast      = rec_q.mcast;
  assign out_pad        = rec_q.pad;
  assign out_l4_bad     = rec_q.l4bad;
  assign out_ip_bad     = rec_q.ipbad;
  assign out_single     = rec_q.single;
  assign out_mpdu_first = rec_q.first;
  assign out_mpdu_last  = rec_q.last;

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
    acc && !in_word[P_CONT] && in_word[P_DROP] |=> !out_valid); // R7
  AST_MCAST_NEEDS_DA: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_mcast |-> out_da_ok); // R6
  AST_ROUTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_intra |-> out_chip == '0 && !out_link); // R9
  AST_SINGLE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_single |-> out_mpdu_first && out_mpdu_last); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid && !err_valid); // R1
endmodule

// File: tb/sim_rx_msdu_chain_asm.sv
module sim_rx_msdu_chain_asm;
  localparam logic [31:0] B_FIRST = 32'h1;
  localparam logic [31:0] B_LAST  = 32'h2;
  localparam logic [31:0] B_CONT  = 32'h4;
  localparam logic [31:0] B_DROP  = 32'h1 << 17;
  localparam logic [31:0] B_SA    = 32'h1 << 18;
  localparam logic [31:0] B_DA    = 32'h1 << 19;
  localparam logic [31:0] B_MC    = 32'h1 << 20;
  localparam logic [31:0] B_PAD   = 32'h1 << 21;
  localparam logic [31:0] B_L4    = 32'h1 << 22;
  localparam logic [31:0] B_IP    = 32'h1 << 23;
  localparam logic [31:0] B_FR    = 32'h1 << 24;
  localparam logic [31:0] B_TO    = 32'h1 << 25;
  localparam logic [31:0] B_INTRA = 32'h1 << 26;
  localparam logic [31:0] B_LINK  = 32'h1 << 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_word = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [13:0] out_len;
  logic [1:0] out_fmt, out_chip, out_pad, err_code;
  logic out_link, out_intra, out_fr_ds, out_to_ds, out_sa_ok, out_da_ok, out_mcast;
  logic out_l4_bad, out_ip_bad, out_single, out_mpdu_first, out_mpdu_last, err_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit mon_on = 0;

  logic [31:0] exp_recs[$];
  logic [1:0]  exp_errs[$];

  // reference state
  bit m_in_msdu = 0;
  bit m_open = 0;
  logic [13:0] m_cap = '0;

  always #5 clk = ~clk;

  rx_msdu_chain_asm u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_fmt(out_fmt),
    .out_chip(out_chip), .out_link(out_link), .out_intra(out_intra), .out_fr_ds(out_fr_ds),
    .out_to_ds(out_to_ds), .out_sa_ok(out_sa_ok), .out_da_ok(out_da_ok), .out_mcast(out_mcast),
    .out_pad(out_pad), .out_l4_bad(out_l4_bad), .out_ip_bad(out_ip_bad), .out_single(out_single),
    .out_mpdu_first(out_mpdu_first), .out_mpdu_last(out_mpdu_last),
    .err_valid(err_valid), .err_code(err_code)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input logic [31:0] flags, input logic [13:0] len,
                                      input logic [1:0] chip, input logic [1:0] fmt);
    return flags | (32'(len) << 3) | (32'(chip) << 27) | (32'(fmt) << 29);
  endfunction

  // expected record: len[31:18] fmt[17:16] chip[15:14] link13 intra12 fr11 to10
  // sa9 da8 mc7 pad[6:5] l4 4 ip3 single2 first1 last0
  function automatic logic [31:0] exp_rec(input logic [31:0] w, input logic [13:0] len);
    logic intra;
    intra = w[26];
    return {len, w[30:29], intra ? w[28:27] : 2'b00, intra & w[31], intra, w[24], w[25],
            w[18], w[19], w[19] & w[20], w[21], 1'b0, w[22], w[23], w[0] & w[1], w[0], w[1]};
  endfunction

  function automatic logic [31:0] act_rec();
    return {out_len, out_fmt, out_chip, out_link, out_intra, out_fr_ds, out_to_ds, out_sa_ok,
            out_da_ok, out_mcast, out_pad, out_l4_bad, out_ip_bad, out_single, out_mpdu_first,
            out_mpdu_last};
  endfunction

  task automatic model(input logic [31:0] w);
    if (w[2] && w[1]) begin
      exp_errs.push_back(2'd1);
      m_in_msdu = 0;
    end else if (w[2]) begin
      if (!m_in_msdu) m_cap = w[16:3];
      m_in_msdu = 1;
    end else begin
      if (w[0] == m_open) exp_errs.push_back(2'd2);
      if (!w[17]) exp_recs.push_back(exp_rec(w, m_in_msdu ? m_cap : w[16:3]));
      m_open = !w[1];
      m_in_msdu = 0;
    end
  endtask

  // called at a falling edge; returns at a falling edge after the handshake
  task automatic send(input logic [31:0] w);
    bit ok;
    in_valid = 1'b1;
    in_word = w;
    do begin
      #4;
      ok = in_ready;
      if (ok) model(w);
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic cmp_rec(input logic [31:0] e, input logic [31:0] a);
    chk(a[31:18] == e[31:18], "R3 length", a[31:18], e[31:18]);
    chk(a[17:16] == e[17:16] && a[12:8] == e[12:8] && a[4:3] == e[4:3] && a[1:0] == e[1:0],
        "R2 closing fields", a, e);
    chk(a[15:13] == e[15:13], "R9 routing", a[15:13], e[15:13]);
    chk(a[7] == e[7], "R6 multicast", a[7], e[7]);
    chk(a[6:5] == e[6:5], "R8 padding", a[6:5], e[6:5]);
    chk(a[2] == e[2], "R5 single", a[2], e[2]);
  endtask

  // monitor: drives out_ready, samples one ns before the rising edge
  initial begin : monitor
    bit held = 0;
    logic [31:0] held_rec = '0;
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 2) != 0);
      #4;
      if (mon_on) begin
        if (held) chk(out_valid && act_rec() == held_rec, "R11 hold", act_rec(), held_rec);
        if (out_valid && !out_ready) begin
          chk(!in_ready, "R11 stall", in_ready, 0);
          held = 1;
          held_rec = act_rec();
        end else held = 0;
        if (out_valid && out_ready) begin
          if (exp_recs.size() == 0) chk(0, "R7 unexpected record", act_rec(), 0);
          else cmp_rec(exp_recs.pop_front(), act_rec());
        end
        if (err_valid) begin
          if (exp_errs.size() == 0) chk(0, "R4 R10 unexpected error", err_code, 0);
          else begin
            logic [1:0] e;
            e = exp_errs.pop_front();
            chk(err_code == e, "R4 R10 error code", err_code, e);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && err_valid == 0 && in_ready == 1, "R1 reset", {out_valid, err_valid, in_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0 && err_valid == 0, "R1 after reset", {out_valid, err_valid}, 0);
    mon_on = 1;
    // R2 R5: single MSDU MPDU
    send(mkw(B_FIRST | B_LAST | B_SA | B_FR | B_L4, 14'd100, 2'd1, 2'd2));
    // R3: three-buffer MSDU, length from opener only
    send(mkw(B_CONT | B_FIRST, 14'd1500, 2'd0, 2'd0));
    send(mkw(B_CONT, 14'd7, 2'd0, 2'd0));
    send(mkw(B_FIRST | B_DA | B_MC | B_IP, 14'd9, 2'd0, 2'd3));
    // R6: multicast without DA valid
    send(mkw(B_MC | B_TO, 14'd60, 2'd0, 2'd1));
    // R8 R9: padding and intra-BSS routing
    send(mkw(B_LAST | B_PAD | B_INTRA | B_LINK, 14'd64, 2'd3, 2'd2));
    send(mkw(B_FIRST | B_LAST | B_LINK, 14'd65, 2'd2, 2'd0));
    // R4: illegal continuation with last
    send(mkw(B_CONT, 14'd300, 2'd0, 2'd0));
    send(mkw(B_CONT | B_LAST, 14'd301, 2'd0, 2'd0));
    send(mkw(B_FIRST | B_LAST, 14'd302, 2'd0, 2'd0));
    // R7: dropped MSDU then a kept one
    send(mkw(B_FIRST | B_LAST | B_DROP, 14'd400, 2'd0, 2'd0));
    send(mkw(B_FIRST | B_LAST | B_SA, 14'd401, 2'd0, 2'd0));
    // R10: orphan close, then reopen while open
    send(mkw('0, 14'd500, 2'd0, 2'd0));
    send(mkw(B_FIRST | B_LAST, 14'd501, 2'd0, 2'd0));
    // random mix
    for (int i = 0; i < 400; i++) send($urandom());
    repeat (30) @(negedge clk);
    chk(exp_recs.size() == 0, "R7 leftover records", exp_recs.size(), 0);
    chk(exp_errs.size() == 0, "R10 leftover errors", exp_errs.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule